// File: doc/BRIEF.md
# External Interrupt Flag Unit

This block watches a small set of external interrupt pins (two by default) and turns their activity into interrupt requests. Each pin first passes through a two-flop synchronizer. A sense detector, set up per pin, then watches for a rising edge, a falling edge, any change, or a held low level. In the three edge modes a detected event sets a sticky pending flag for that pin. The CPU sees the flags in one 8-bit register on a simple read/write port.

A request goes to the CPU for a pin when three things are all set: its pending flag, that pin's enable bit, and the global interrupt enable. A flag can be cleared in three ways. The CPU can acknowledge the matching vector, software can write a one to the flag's bit, or the pin can be in level mode, which holds the flag at zero. In level mode the request comes straight from the synchronized low level of the pin, so it stays raised for as long as the pin is held low.

Top module: `extint_flag_unit`

## Requirements
- R1: After reset, every flag and every request output is zero.
- R2: In the register, bit 0 is the flag of pin 0 and bit 1 is the flag of pin 1. Bits 7 to 2 always read zero, and writes to them have no effect.
- R3: The 2-bit sense code for pin i sits at sense_cfg[2i+1:2i]. The codes are 00 low level, 01 any change, 10 falling edge and 11 rising edge. In the three edge modes, a matching transition of the synchronized pin sets its flag to one, and a non-matching transition leaves it alone.
- R4: In edge modes, irq[i] is high exactly when flag i, mask_en[i] and global_ie are all one.
- R5: A pulse on ack[i] clears flag i on the next clock.
- R6: A register write with a one in bit i clears flag i. A write with a zero in bit i leaves flag i unchanged.
- R7: While pin i is in level mode (code 00), its flag reads zero.
- R8: In level mode, irq[i] is high while the synchronized pin is low and both mask_en[i] and global_ie are one. It drops once the synchronized pin is high again.
- R9: A pin change applied between clock edges shows in the flag after the third rising clock edge. It does not show after the second.
- R10: If an event is detected in the same cycle as a clear by acknowledge or by write-one, the flag ends up at one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| sense_cfg | input | 2*NUM_PINS | Per-pin sense code, two bits per pin |
| mask_en | input | NUM_PINS | Per-pin request enable |
| global_ie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Write strobe for the flag register |
| reg_wdata | input | REG_W | Write data; a one in a flag bit clears that flag |
| reg_rdata | output | REG_W | Flag register read value |
| ack | input | NUM_PINS | Per-vector acknowledge from the CPU |
| irq | output | NUM_PINS | Interrupt requests |

## Verification
The bench probes the exact latency of the synchronizer and edge compare. A design with one stage too few or too many would set the flag a cycle early or late. It applies each edge polarity in each mode, so a design that swapped the rising and falling codes would set flags on the wrong transitions. It lines up an edge event with an acknowledge and a write-one in the same cycle. A design that gave the clear priority would drop an interrupt there. It also writes ones to the reserved bits and zeros to flag bits, to catch a register that decodes those bits or clears on any write. In level mode it checks that the request follows the pin while the flag stays at zero.

// File: rtl/extint_pkg.sv
package extint_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Edge event for one pin from its current and previous synchronized level.
  function automatic logic sense_event(sense_e mode, logic cur, logic prev);
    case (mode)
      SENSE_ANY:  return cur ^ prev;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return cur & ~prev;
      default:    return 1'b0;
    endcase
  endfunction

  // Request for one pin, gated by both enables.
  function automatic logic gate_req(logic level_mode, logic cur, logic flag,
                                    logic mask, logic gie);
    logic src;
    src = level_mode ? ~cur : flag;
    return src & mask & gie;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extint_sense.sv
module extint_sense
  import extint_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       cur,
  output logic       evt,
  output logic       level_mode
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= cur;
  end

  assign evt        = sense_event(sense_e'(mode), cur, prev);
  assign level_mode = (sense_e'(mode) == SENSE_LOW);
endmodule

// File: rtl/extint_flag.sv
module extint_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic level_mode,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag <= 1'b0;
    else if (level_mode) flag <= 1'b0;
    else if (evt)        flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end
endmodule

// File: rtl/extint_flag_unit.sv
module extint_flag_unit
  import extint_pkg::*;
#(
  parameter int   NUM_PINS    = 2,
  parameter int   REG_W       = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LEVEL  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [2*NUM_PINS-1:0] sense_cfg,
  input  logic [NUM_PINS-1:0]   mask_en,
  input  logic                  global_ie,
  input  logic                  reg_wr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic [NUM_PINS-1:0]   ack,
  output logic [NUM_PINS-1:0]   irq
);
  localparam int RSVD_W = REG_W - NUM_PINS;

  logic [NUM_PINS-1:0] sync_w;
  logic [NUM_PINS-1:0] evt_w;
  logic [NUM_PINS-1:0] level_w;
  logic [NUM_PINS-1:0] clr_w;
  logic [NUM_PINS-1:0] flag_w;
  logic                wdata_unused;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    extint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVEL)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in[i]), .q(sync_w[i])
    );

    extint_sense #(.RST_VAL(IDLE_LEVEL)) u_sense (
      .clk(clk), .rst_n(rst_n), .mode(sense_cfg[2*i +: 2]),
      .cur(sync_w[i]), .evt(evt_w[i]), .level_mode(level_w[i])
    );

    assign clr_w[i] = ack[i] | (reg_wr & reg_wdata[i]);

    extint_flag u_flag (
      .clk(clk), .rst_n(rst_n), .evt(evt_w[i]), .level_mode(level_w[i]),
      .clr(clr_w[i]), .flag(flag_w[i])
    );

    assign irq[i] = gate_req(level_w[i], sync_w[i], flag_w[i], mask_en[i], global_ie);
  end

  assign reg_rdata    = {{RSVD_W{1'b0}}, flag_w};
  assign wdata_unused = ^reg_wdata[REG_W-1:NUM_PINS];
endmodule

// File: rtl/extint_flag_unit_chk.sv
module extint_flag_unit_chk #(
  parameter int NUM_PINS = 2,
  parameter int REG_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [REG_W-1:0]    reg_rdata,
  input logic [NUM_PINS-1:0] irq,
  input logic [NUM_PINS-1:0] mask_en,
  input logic                global_ie,
  input logic [NUM_PINS-1:0] ack,
  input logic                reg_wr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [NUM_PINS-1:0] evt,
  input logic [NUM_PINS-1:0] level_mode
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NUM_PINS] == '0); // R2

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> reg_rdata[i]); // R10

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !evt[i]) |=> !reg_rdata[i]); // R5

    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      level_mode[i] |=> !reg_rdata[i]); // R7

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> (mask_en[i] && global_ie)); // R4

    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[i] && !ack[i] && !level_mode[i] && !(reg_wr && reg_wdata[i]))
        |=> reg_rdata[i]); // R6
  end
endmodule

bind extint_flag_unit extint_flag_unit_chk #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .irq(irq),
  .mask_en(mask_en), .global_ie(global_ie), .ack(ack), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .evt(evt_w), .level_mode(level_w)
);

// File: tb/extint_flag_unit_test.sv
module extint_flag_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // {pin, mode[1:0], from, to, expected flag}
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 1'b1, 1'b0, 1'b1},
    {1'b0, 2'b01, 1'b0, 1'b1, 1'b1},
    {1'b0, 2'b01, 1'b1, 1'b1, 1'b0},
    {1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b0},
    {1'b0, 2'b11, 1'b0, 1'b1, 1'b1},
    {1'b0, 2'b11, 1'b1, 1'b0, 1'b0},
    {1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'b01, 1'b0, 1'b1, 1'b1},
    {1'b1, 2'b10, 1'b1, 1'b0, 1'b1},
    {1'b1, 2'b10, 1'b0, 1'b1, 1'b0},
    {1'b1, 2'b11, 1'b0, 1'b1, 1'b1},
    {1'b1, 2'b11, 1'b1, 1'b0, 1'b0},
    {1'b1, 2'b00, 1'b0, 1'b1, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_in = 2'b11;
  logic [3:0] sense_cfg = 4'b1111;
  logic [1:0] mask_en = 2'b00;
  logic       global_ie = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] ack = 2'b00;
  logic [1:0] irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  extint_flag_unit uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sense_cfg(sense_cfg),
    .mask_en(mask_en), .global_ie(global_ie), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack(ack), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = 8'h00;
  endtask

  initial begin
    // R1: reset state
    wait_neg(3);
    chk("R1 flags after reset", reg_rdata, 8'h00);
    chk("R1 irq after reset", {6'd0, irq}, 8'h00);
    rst_n = 1'b1;
    wait_neg(4);
    chk("R1 no flag after release", reg_rdata, 8'h00);

    // R3 table walk, flag i at bit i of the register
    for (int v = 0; v < NVEC; v++) begin
      logic p;
      logic [1:0] m;
      p = VEC[v][5];
      m = VEC[v][4:3];
      pin_in = 2'b11;
      pin_in[p] = VEC[v][2];
      sense_cfg = 4'b1111;
      sense_cfg[2*p +: 2] = m;
      wait_neg(4);
      write_reg(8'hFF);
      pin_in[p] = VEC[v][1];
      wait_neg(4);
      chk($sformatf("R3 vector %0d", v), reg_rdata, p ? {6'd0, VEC[v][0], 1'b0} : {7'd0, VEC[v][0]});
    end

    // R9: latency of synchronizer and edge compare
    sense_cfg = 4'b0101;
    pin_in = 2'b11;
    wait_neg(4);
    write_reg(8'hFF);
    pin_in[0] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 not yet after two edges", reg_rdata, 8'h00);
    @(posedge clk); #1;
    chk("R9 set after third edge", reg_rdata, 8'h01);

    // R2, R6: reserved bits and write-one-to-clear
    pin_in[1] = 1'b0;
    wait_neg(4);
    chk("R2 both flags set", reg_rdata, 8'h03);
    write_reg(8'hFC);
    chk("R2 reserved write ignored", reg_rdata, 8'h03);
    write_reg(8'h01);
    chk("R6 write one clears bit0 only", reg_rdata, 8'h02);
    write_reg(8'h02);
    chk("R6 write one clears bit1", reg_rdata, 8'h00);

    // R4: request gating, R5: acknowledge
    sense_cfg = 4'b1010;
    pin_in = 2'b11;
    wait_neg(4);
    write_reg(8'hFF);
    pin_in[0] = 1'b0;
    wait_neg(4);
    mask_en = 2'b00; global_ie = 1'b1; #1;
    chk("R4 masked pin no irq", {6'd0, irq}, 8'h00);
    mask_en = 2'b01; global_ie = 1'b0; #1;
    chk("R4 global off no irq", {6'd0, irq}, 8'h00);
    global_ie = 1'b1; #1;
    chk("R4 irq raised", {6'd0, irq}, 8'h01);
    @(negedge clk); ack = 2'b01;
    @(negedge clk); ack = 2'b00;
    chk("R5 ack clears flag", reg_rdata, 8'h00);
    chk("R5 irq drops after ack", {6'd0, irq}, 8'h00);

    // R10: event in the same cycle as ack and write-one
    pin_in = 2'b11;
    wait_neg(4);
    write_reg(8'hFF);
    @(negedge clk); pin_in[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h01; ack = 2'b01;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = 8'h00; ack = 2'b00;
    chk("R10 set wins over clear", reg_rdata, 8'h01);

    // R7, R8: level mode
    sense_cfg = 4'b1100;
    pin_in = 2'b11;
    wait_neg(4);
    chk("R7 level mode holds flag zero", reg_rdata, 8'h00);
    chk("R8 no irq while pin high", {6'd0, irq}, 8'h00);
    pin_in[0] = 1'b0;
    wait_neg(4);
    chk("R8 irq while pin low", {6'd0, irq}, 8'h01);
    chk("R7 flag zero while pin low", reg_rdata, 8'h00);
    pin_in[0] = 1'b1;
    wait_neg(4);
    chk("R8 irq drops when pin high", {6'd0, irq}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule